// File: doc/BRIEF.md
# Combined Mealy-Moore Sequence Controller

This block is a five-state synchronous controller that steps through a fixed pattern driven by two single-bit inputs: an advance request and a hold request. It keeps its state in a 3-bit register using plain binary codes. Each cycle it produces two outputs. The pulse output is Mealy-style: it depends on the current state and on the inputs in that same cycle. The level output is Moore-style: it depends on the state alone.

The sequence runs through five states: idle, armed, fire, wait and done. The hold request matters only in the wait state, where it parks the machine for as long as it stays high. The current state code is brought out so that the surrounding logic, or a bench, can follow the sequence.

A synchronous active-high reset returns the machine to idle. Codes that no state uses fall back to idle, with both outputs low.

Top module: `seq_ctrl_mm`

## Requirements
- R1: While `rst` is high at a rising edge, the next state code is 000 (idle), and `level_out` is 0 after that edge. This applies even in the middle of a sequence.
- R2: In idle (000), `adv_in`=0 keeps the state at 000 with `pulse_out`=1. `hold_in` has no effect in idle.
- R3: In idle, `adv_in`=1 moves the state to 001 (armed) with `pulse_out`=0.
- R4: In armed (001), `adv_in`=0 returns the state to 000 with `pulse_out`=0. `adv_in`=1 moves it to 010 (fire) with `pulse_out`=1.
- R5: Fire (010) always moves to 011 (wait), with `pulse_out`=0, whatever the inputs are.
- R6: In wait (011), `hold_in`=1 keeps the state at 011 with `pulse_out`=0, whatever `adv_in` is.
- R7: In wait with `hold_in`=0, `adv_in`=0 moves the state to 000 and `adv_in`=1 moves it to 100 (done). `pulse_out` is 1 in both cases.
- R8: Done (100) always returns to 000, with `pulse_out`=0.
- R9: `level_out` is 1 in states 001, 011 and 100, and 0 in states 000 and 010.
- R10: `pulse_out` follows a change of `adv_in` or `hold_in` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_in | input | 1 | Advance request |
| hold_in | input | 1 | Hold request, acted on only in the wait state |
| pulse_out | output | 1 | Mealy output, from state and inputs |
| level_out | output | 1 | Moore output, from state only |
| state_code | output | 3 | Current state register value |

## Verification
In the wait state, both the hold request and the advance request can be high in the same cycle. The bench drives both high there, with the advance request high and with it low. It expects the machine to stay in wait with the pulse output low, because hold takes priority. The bench also changes the advance input in the middle of a cycle, once the state has settled. It then checks that the pulse output has already moved before the next edge, while the state code and level output stay where they were.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;
  localparam int unsigned STATE_W = 3;

  localparam logic [STATE_W-1:0] ST_IDLE  = 3'd0;
  localparam logic [STATE_W-1:0] ST_ARMED = 3'd1;
  localparam logic [STATE_W-1:0] ST_FIRE  = 3'd2;
  localparam logic [STATE_W-1:0] ST_WAIT  = 3'd3;
  localparam logic [STATE_W-1:0] ST_DONE  = 3'd4;
endpackage

// File: rtl/mm_next_state.sv
module mm_next_state
  import seq_ctrl_pkg::*;
(
  input  logic [STATE_W-1:0] cur_state,
  input  logic               adv,
  input  logic               hold,
  output logic [STATE_W-1:0] nxt_state,
  output logic               pulse
);
  always_comb begin
    nxt_state = ST_IDLE;
    pulse     = 1'b0;
    case (cur_state)
      ST_IDLE: begin
        nxt_state = adv ? ST_ARMED : ST_IDLE;
        pulse     = ~adv;
      end
      ST_ARMED: begin
        nxt_state = adv ? ST_FIRE : ST_IDLE;
        pulse     = adv;
      end
      ST_FIRE: begin
        nxt_state = ST_WAIT;
        pulse     = 1'b0;
      end
      ST_WAIT: begin
        if (hold) begin
          nxt_state = ST_WAIT;
          pulse     = 1'b0;
        end else begin
          nxt_state = adv ? ST_DONE : ST_IDLE;
          pulse     = 1'b1;
        end
      end
      ST_DONE: begin
        nxt_state = ST_IDLE;
        pulse     = 1'b0;
      end
      default: begin
        nxt_state = ST_IDLE;
        pulse     = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mm_level_dec.sv
module mm_level_dec
  import seq_ctrl_pkg::*;
(
  input  logic [STATE_W-1:0] code,
  output logic               level
);
  always_comb begin
    case (code)
      ST_ARMED, ST_WAIT, ST_DONE: level = 1'b1;
      default:                    level = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_ctrl_mm.sv
module seq_ctrl_mm
  import seq_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_in,
  input  logic         hold_in,
  output logic         pulse_out,
  output logic         level_out,
  output logic [2:0]   state_code
);
  logic [STATE_W-1:0] st_q;
  logic [STATE_W-1:0] st_d;
  logic               pulse_c;
  logic               level_d;
  logic               level_q;

  mm_next_state u_next (
    .cur_state (st_q),
    .adv       (adv_in),
    .hold      (hold_in),
    .nxt_state (st_d),
    .pulse     (pulse_c)
  );

  // Decode the level from the next state so the registered copy lines up with st_q
  mm_level_dec u_level (
    .code  (st_d),
    .level (level_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      level_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      level_q <= level_d;
    end
  end

  assign pulse_out  = pulse_c;
  assign level_out  = level_q;
  assign state_code = st_q;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (st_q == ST_IDLE && !level_q)); // R1
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !adv_in) |=> st_q == ST_IDLE); // R2
  AST_FIRE_TO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FIRE) |=> st_q == ST_WAIT); // R5
  AST_HOLD_PARKS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && hold_in) |=> st_q == ST_WAIT); // R6
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE) |=> st_q == ST_IDLE); // R8
  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    level_q == (st_q == ST_ARMED || st_q == ST_WAIT || st_q == ST_DONE)); // R9
  AST_CODE_USED: assert property (@(posedge clk) disable iff (rst)
    st_q <= ST_DONE); // R1
endmodule

// File: tb/sim_seq_ctrl_mm.sv
`timescale 1ns/1ps
module sim_seq_ctrl_mm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv_in = 1'b0;
  logic hold_in = 1'b0;
  logic pulse_out, level_out;
  logic [2:0] state_code;

  int checks = 0;
  int fails = 0;
  int ref_st = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seq_ctrl_mm u0 (
    .clk(clk), .rst(rst), .adv_in(adv_in), .hold_in(hold_in),
    .pulse_out(pulse_out), .level_out(level_out), .state_code(state_code)
  );

  function automatic int ref_next(int s, bit a, bit h);
    if (s == 0) return a ? 1 : 0;
    if (s == 1) return a ? 2 : 0;
    if (s == 2) return 3;
    if (s == 3) return h ? 3 : (a ? 4 : 0);
    return 0;
  endfunction

  function automatic bit ref_pulse(int s, bit a, bit h);
    if (s == 0) return !a;
    if (s == 1) return a;
    if (s == 3) return !h;
    return 1'b0;
  endfunction

  function automatic bit ref_level(int s);
    return (s == 1 || s == 3 || s == 4);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs, compare outputs against the model, then advance it
  task automatic step(bit a, bit h, string req);
    @(negedge clk);
    adv_in = a;
    hold_in = h;
    #2;
    check(req, int'(state_code), ref_st, "state");
    check("R9", int'(level_out), int'(ref_level(ref_st)), "level");
    check(req, int'(pulse_out), int'(ref_pulse(ref_st, a, h)), "pulse");
    ref_st = ref_next(ref_st, a, h);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    check("R1", int'(state_code), 0, "reset state");
    check("R1", int'(level_out), 0, "reset level");

    step(0, 1, "R2");   // idle, hold ignored
    step(0, 0, "R2");
    step(1, 1, "R3");   // idle -> armed, hold ignored
    step(0, 0, "R4");   // armed -> idle
    step(1, 0, "R3");
    step(1, 0, "R4");   // armed -> fire
    step(0, 1, "R5");   // fire -> wait
    step(1, 1, "R6");   // hold beats advance
    step(0, 1, "R6");
    step(1, 0, "R7");   // wait -> done
    step(0, 1, "R8");   // done -> idle
    step(1, 0, "R3");
    step(1, 0, "R4");
    step(1, 0, "R5");
    step(0, 0, "R7");   // wait -> idle
    step(0, 0, "R2");

    // R10: pulse reacts to an input change inside one cycle
    @(negedge clk);
    adv_in = 1'b0;
    #2;
    check("R10", int'(pulse_out), 1, "pulse adv=0");
    adv_in = 1'b1;
    #2;
    check("R10", int'(pulse_out), 0, "pulse adv=1 same cycle");
    check("R10", int'(state_code), 0, "state unchanged mid-cycle");
    ref_st = ref_next(ref_st, 1'b1, 1'b0);

    step(1, 0, "R4");
    step(1, 0, "R5");
    step(1, 1, "R6");

    // R1: reset in the middle of a sequence
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    adv_in = 1'b0;
    hold_in = 1'b0;
    #2;
    check("R1", int'(state_code), 0, "mid-run reset state");
    check("R1", int'(level_out), 0, "mid-run reset level");
    ref_st = 0;
    step(0, 0, "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule